// File: doc/BRIEF.md
# Memory-read CRC-16 response sequencer

This block follows the byte stream of a read transaction on a serial memory device. It decides when to clear a 16-bit CRC accumulator and which bytes go into it. It also decides when the complemented CRC is placed into the outgoing stream. A transaction opens with a one-cycle `start` pulse that carries the read mode. Every byte that crosses the bus is then announced with `byte_valid`. That byte is either a command byte, an address byte, a redirection byte or a data byte, and `addr` gives the memory location of the data byte being transferred.

Three read modes are supported. The plain read sends a single CRC when the data memory is exhausted. The status read sends a CRC at every 8-byte page. The extended read sends one CRC after each redirection byte and another at each data page end. When the block asks for an insertion, it raises `crc_req` for exactly two cycles and drives the two CRC bytes on `crc_byte`. The bus logic around the block forwards those bytes to the master. The memory array, the redirection-byte contents and the physical bus sit outside this block.

Top module: `crc_read_seq`

## Requirements
- R1: The accumulator uses the polynomial x^16 + x^15 + x^2 + 1. Bytes are processed least significant bit first with the reflected feedback constant 0xA001, and each cleared accumulator starts from 0x0000.
- R2: An insertion raises `crc_req` for exactly two consecutive cycles. `crc_byte` carries the low byte of the bitwise complement of the accumulator in the first cycle and the high byte in the second. `crc_byte` is 0 whenever `crc_req` is low.
- R3: A `start` pulse latches `rd_mode`, clears the accumulator and begins a new transaction, aborting any transaction in progress. The next three strobed bytes are the command, the address low byte and the address high byte, and all three are folded into the CRC.
- R4: In plain mode (`rd_mode` 0, and also the unused code 3), every data byte is folded in. The only insertion follows the data byte whose `addr` equals MEM_BYTES-1. After that insertion, strobes have no effect until the next `start`.
- R5: In status mode (`rd_mode` 1), an insertion follows each data byte whose `addr[2:0]` equals 7. The first one covers the command byte, both address bytes and the data bytes up to that page end.
- R6: After every insertion the accumulator is cleared. In status mode, each later page CRC therefore covers only that page's data bytes.
- R7: In extended mode (`rd_mode` 2), the fourth strobed byte is a redirection byte and is followed by an insertion. That CRC covers the command, the two address bytes and the redirection byte.
- R8: In extended mode, the data bytes after a redirection CRC are folded into a cleared accumulator. An insertion follows the byte whose `addr` modulo PAGE_BYTES equals PAGE_BYTES-1. The next strobed byte is the redirection byte of the following page, and its CRC covers that byte alone.
- R9: Strobes that arrive during the two insertion cycles are ignored and do not change any later CRC.
- R10: After reset `crc_req` and `crc_byte` are 0, and strobes before the first `start` cause no insertion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that opens a transaction |
| rd_mode | input | 2 | Read mode: 0 plain, 1 status, 2 extended, 3 plain |
| byte_valid | input | 1 | A byte crosses the bus this cycle |
| byte_data | input | 8 | Value of the strobed byte |
| addr | input | $clog2(MEM_BYTES) | Memory address of the strobed data byte |
| crc_req | output | 1 | Two-cycle request to insert the CRC |
| crc_byte | output | 8 | Complemented CRC byte, low byte then high byte |

## Verification
The bench goes after the places where the accumulator must be cleared. These are a status page after the first one, the redirection byte of a second extended page, and a transaction restarted halfway through. A design that forgets one of these clears sends a CRC that still contains the command and address bytes. In every insertion window the bench also strobes a junk byte that carries the memory's last address. A design that folded that byte in, or that treated it as a page end, would corrupt the next CRC or make a third request cycle. Plain-mode strobes after the final insertion and strobes before any start must leave `crc_req` low. An off-by-one in the page-end compare would move an insertion by one byte, and the bench would catch it.

// File: rtl/crs_pkg.sv
package crs_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN  = 2'd0,
        MODE_STATUS = 2'd1,
        MODE_EXT    = 2'd2,
        MODE_ALT    = 2'd3
    } rd_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HDR,
        PH_REDIR,
        PH_DATA,
        PH_CRC_LO,
        PH_CRC_HI,
        PH_DONE
    } phase_e;

    typedef struct packed {
        phase_e     phase;
        phase_e     resume;
        rd_mode_e   mode;
        logic [1:0] hdr_cnt;
        logic [15:0] crc;
    } seq_state_t;

endpackage

// File: rtl/crs_crc_byte.sv
module crs_crc_byte #(
    parameter logic [15:0] POLY = 16'hA001
) (
    input  logic [15:0] crc_in,
    input  logic [7:0]  din,
    output logic [15:0] crc_out
);
    // Folds one byte in, least significant bit first, reflected form.
    always_comb begin
        logic [15:0] v;
        v = crc_in;
        for (int i = 0; i < 8; i++) begin
            if (v[0] ^ din[i]) v = (v >> 1) ^ POLY;
            else               v = v >> 1;
        end
        crc_out = v;
    end
endmodule

// File: rtl/crs_end_detect.sv
module crs_end_detect
    import crs_pkg::*;
#(
    parameter int MEM_BYTES  = 512,
    parameter int PAGE_BYTES = 32,
    parameter int STAT_PAGE  = 8,
    localparam int ADDR_W    = $clog2(MEM_BYTES)
) (
    input  rd_mode_e           mode,
    input  logic [ADDR_W-1:0]  addr,
    output logic               boundary
);
    localparam int  PG_W     = $clog2(PAGE_BYTES);
    localparam int  ST_W     = $clog2(STAT_PAGE);
    localparam bit  PG_POW2  = (PAGE_BYTES & (PAGE_BYTES - 1)) == 0;
    localparam bit  ST_POW2  = (STAT_PAGE & (STAT_PAGE - 1)) == 0;

    logic ext_end;
    logic stat_end;
    logic mem_end;

    assign mem_end = (int'(addr) == MEM_BYTES - 1);

    generate
        if (PG_POW2) begin : g_pg_mask
            assign ext_end = (addr[PG_W-1:0] == PG_W'(PAGE_BYTES - 1));
        end else begin : g_pg_mod
            assign ext_end = ((int'(addr) % PAGE_BYTES) == PAGE_BYTES - 1);
        end
        if (ST_POW2) begin : g_st_mask
            assign stat_end = (addr[ST_W-1:0] == ST_W'(STAT_PAGE - 1));
        end else begin : g_st_mod
            assign stat_end = ((int'(addr) % STAT_PAGE) == STAT_PAGE - 1);
        end
    endgenerate

    always_comb begin
        unique case (mode)
            MODE_STATUS: boundary = stat_end;
            MODE_EXT:    boundary = ext_end;
            default:     boundary = mem_end;
        endcase
    end
endmodule

// File: rtl/crc_read_seq.sv
module crc_read_seq
    import crs_pkg::*;
#(
    parameter int          MEM_BYTES  = 512,
    parameter int          PAGE_BYTES = 32,
    parameter int          STAT_PAGE  = 8,
    parameter logic [15:0] POLY       = 16'hA001,
    localparam int         ADDR_W     = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        rd_mode,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic [ADDR_W-1:0] addr,
    output logic              crc_req,
    output logic [7:0]        crc_byte
);
    localparam logic [1:0] HDR_LAST = 2'd2;

    seq_state_t state_d, state_q;
    logic [15:0] crc_step;
    logic        at_boundary;

    crs_crc_byte #(.POLY(POLY)) u_step (
        .crc_in (state_q.crc),
        .din    (byte_data),
        .crc_out(crc_step)
    );

    crs_end_detect #(
        .MEM_BYTES (MEM_BYTES),
        .PAGE_BYTES(PAGE_BYTES),
        .STAT_PAGE (STAT_PAGE)
    ) u_end (
        .mode    (state_q.mode),
        .addr    (addr),
        .boundary(at_boundary)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q.phase)
            PH_HDR: begin
                if (byte_valid) begin
                    state_d.crc = crc_step;
                    if (state_q.hdr_cnt == HDR_LAST) begin
                        state_d.phase = (state_q.mode == MODE_EXT) ? PH_REDIR : PH_DATA;
                    end else begin
                        state_d.hdr_cnt = state_q.hdr_cnt + 2'd1;
                    end
                end
            end
            PH_REDIR: begin
                if (byte_valid) begin
                    state_d.crc    = crc_step;
                    state_d.phase  = PH_CRC_LO;
                    state_d.resume = PH_DATA;
                end
            end
            PH_DATA: begin
                if (byte_valid) begin
                    state_d.crc = crc_step;
                    if (at_boundary) begin
                        state_d.phase = PH_CRC_LO;
                        unique case (state_q.mode)
                            MODE_STATUS: state_d.resume = PH_DATA;
                            MODE_EXT:    state_d.resume = PH_REDIR;
                            default:     state_d.resume = PH_DONE;
                        endcase
                    end
                end
            end
            PH_CRC_LO: state_d.phase = PH_CRC_HI;
            PH_CRC_HI: begin
                state_d.crc   = 16'h0000;
                state_d.phase = state_q.resume;
            end
            default: ;
        endcase

        if (start) begin
            state_d.phase   = PH_HDR;
            state_d.mode    = rd_mode_e'(rd_mode);
            state_d.hdr_cnt = 2'd0;
            state_d.crc     = 16'h0000;
            state_d.resume  = PH_DONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{phase: PH_IDLE, resume: PH_DONE, mode: MODE_PLAIN,
                         hdr_cnt: 2'd0, crc: 16'h0000};
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        crc_req  = 1'b0;
        crc_byte = 8'h00;
        if (state_q.phase == PH_CRC_LO) begin
            crc_req  = 1'b1;
            crc_byte = ~state_q.crc[7:0];
        end else if (state_q.phase == PH_CRC_HI) begin
            crc_req  = 1'b1;
            crc_byte = ~state_q.crc[15:8];
        end
    end
endmodule

// File: rtl/crs_chk.sv
module crs_chk
    import crs_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        crc_req,
    input phase_e      phase,
    input logic [15:0] crc_acc
);
    // R2: a request never lasts a single cycle
    a_r2_pair_second: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(crc_req) && !start) |=> crc_req);

    // R2: a request never lasts more than two cycles
    a_r2_pair_len: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_req && $past(crc_req)) |=> !crc_req);

    // R3: a start always cuts off any request
    a_r3_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !crc_req);

    // R9: the accumulator holds while the low byte goes out
    a_r9_hold_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CRC_LO && !start) |=> (crc_acc == $past(crc_acc)));

    // R6: the accumulator is empty once an insertion completes
    a_r6_clear_after: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CRC_HI) |=> (crc_acc == 16'h0000));
endmodule

bind crc_read_seq crs_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .crc_req(crc_req),
    .phase  (state_q.phase),
    .crc_acc(state_q.crc)
);

// File: tb/sim_crc_read_seq.sv
`timescale 1ns/1ps
module sim_crc_read_seq;
    localparam int MEM  = 512;
    localparam int PAGE = 32;
    localparam int SPG  = 8;

    typedef struct packed {
        logic [1:0] mode;
        logic [9:0] st;
        logic [9:0] cnt;
        logic [7:0] cmd;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{2'd0, 10'd500, 10'd0,  8'hF0},
        '{2'd0, 10'd0,   10'd0,  8'h0F},
        '{2'd1, 10'd5,   10'd20, 8'hAA},
        '{2'd1, 10'd0,   10'd16, 8'hAA},
        '{2'd2, 10'd30,  10'd40, 8'hA5},
        '{2'd2, 10'd0,   10'd32, 8'hA5},
        '{2'd3, 10'd508, 10'd0,  8'h3C}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] rd_mode = 2'd0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic [8:0] addr = 9'd0;
    logic       crc_req;
    logic [7:0] crc_byte;

    int  checks = 0;
    int  failures = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    crc_read_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_mode(rd_mode),
        .byte_valid(byte_valid), .byte_data(byte_data), .addr(addr),
        .crc_req(crc_req), .crc_byte(crc_byte)
    );

    function automatic logic [15:0] crc_add(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] v = c;
        for (int i = 0; i < 8; i++) begin
            if (v[0] ^ d[i]) v = (v >> 1) ^ 16'hA001;
            else             v = v >> 1;
        end
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drives one byte; when last is set, checks the insertion pair (R2)
    // and strobes junk during it (R9).
    task automatic send(input logic [7:0] d, input int a, input bit last,
                        input logic [15:0] m, input string tag);
        byte_valid = 1'b1; byte_data = d; addr = 9'(a);
        @(negedge clk);
        byte_valid = 1'b0;
        if (!last) begin
            chk(crc_req == 1'b0, tag, {15'd0, crc_req}, 16'd0);
        end else begin
            chk(crc_req && crc_byte == ~m[7:0], {tag, " R2 low"}, {7'd0, crc_req, crc_byte}, {8'h01, ~m[7:0]});
            byte_valid = 1'b1; byte_data = 8'hFF; addr = 9'(MEM - 1);
            @(negedge clk);
            chk(crc_req && crc_byte == ~m[15:8], {tag, " R2 high R9"}, {7'd0, crc_req, crc_byte}, {8'h01, ~m[15:8]});
            @(negedge clk);
            byte_valid = 1'b0;
            chk(crc_req == 1'b0, "R2 length", {15'd0, crc_req}, 16'd0);
        end
    endtask

    task automatic pulse_start(input logic [1:0] md);
        @(negedge clk);
        start = 1'b1; rd_mode = md;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(input logic [1:0] md, input int st, input int cnt, input logic [7:0] cmd);
        logic [15:0] m;
        int n;
        bit last;
        bit first_pg;
        logic [7:0] d;
        pulse_start(md);
        m = 16'h0000;
        m = crc_add(m, cmd);          send(cmd, 0, 1'b0, m, "R3");
        m = crc_add(m, 8'(st));       send(8'(st), 0, 1'b0, m, "R3");
        m = crc_add(m, 8'(st >> 8));  send(8'(st >> 8), 0, 1'b0, m, "R3");
        if (md == 2'd2) begin
            d = 8'h5A ^ 8'(st);
            m = crc_add(m, d);
            send(d, 0, 1'b1, m, "R7");
            m = 16'h0000;
        end
        n = (md == 2'd0 || md == 2'd3) ? MEM - st : cnt;
        first_pg = 1'b1;
        for (int i = 0; i < n; i++) begin
            int a = st + i;
            d = 8'((a * 37 + 11) ^ int'(cmd));
            m = crc_add(m, d);
            unique case (md)
                2'd1:    last = (a % SPG) == SPG - 1;
                2'd2:    last = (a % PAGE) == PAGE - 1;
                default: last = (a == MEM - 1);
            endcase
            if (md == 2'd1)      send(d, a, last, m, first_pg ? "R5" : "R6");
            else if (md == 2'd2) send(d, a, last, m, "R8");
            else                 send(d, a, last, m, "R4");
            if (last) begin
                m = 16'h0000;
                first_pg = 1'b0;
                if (md == 2'd2 && i < n - 1) begin
                    d = 8'hC3 ^ 8'(a);
                    m = crc_add(16'h0000, d);
                    send(d, 0, 1'b1, m, "R8 next redirection");
                    m = 16'h0000;
                end
            end
        end
        if (md == 2'd0 || md == 2'd3) begin
            send(8'h11, MEM - 1, 1'b0, 16'h0, "R4 after end");
            send(8'h22, MEM - 1, 1'b0, 16'h0, "R4 after end");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(crc_req == 1'b0 && crc_byte == 8'h00, "R10 reset", {7'd0, crc_req, crc_byte}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(crc_req == 1'b0 && crc_byte == 8'h00, "R10 after reset", {7'd0, crc_req, crc_byte}, 16'd0);
        // R10: strobes before any start, including at the last address
        send(8'h77, MEM - 1, 1'b0, 16'h0, "R10 idle");
        send(8'h07, 7, 1'b0, 16'h0, "R10 idle");
        send(8'h1F, 31, 1'b0, 16'h0, "R10 idle");

        for (int v = 0; v < 7; v++) begin
            run(VECS[v].mode, int'(VECS[v].st), int'(VECS[v].cnt), VECS[v].cmd);
        end

        // R3: abort an extended read partway, then a status read must be clean
        pulse_start(2'd2);
        send(8'hA5, 0, 1'b0, 16'h0, "R3 abort");
        send(8'h10, 0, 1'b0, 16'h0, "R3 abort");
        run(2'd1, 3, 14, 8'hAA);

        // R4: plain read restarted right at the final address
        run(2'd0, MEM - 1, 0, 8'hF0);

        // R1/R8: extended read that starts on the last byte of a page
        run(2'd2, PAGE - 1, PAGE + 1, 8'hA5);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule